// File: doc/BRIEF.md
# Indexed bank-select page mapper

This block sits on the processor's write path and turns bus writes into page numbers for program and character memory. The processor does not write bank numbers directly. It first writes a select register, which names one of eight bank registers and sets two layout modes. It then writes a data port, which loads the named bank register. From the eight registers and the two modes the block produces four 8 KB program-page numbers and eight 1 KB character-page numbers, one for each address window. It also keeps a one-bit mirroring control.

Only address bits 15..13 and bit 0 take part in decoding. The sizes of program and character memory are parameters, given in pages. Every stored bank value is reduced into range when it is written, so the outputs always address an existing page. The page outputs are registered. They are reloaded only after a data-port write, so a change of mode alone does not move any window.

Top module: `bank_page_mapper`

## Requirements
- R1: After reset, the program slots read 0, 1, PRG_PAGES-2 and PRG_PAGES-1, the character slots 0..7 read 0..7, and mirror_out reads 0. The bank registers 0..7 hold 0, 2, 4, 5, 6, 7, 0, 1.
- R2: Only wr_addr AND 0xE001 is decoded, so an address such as 0x9FFF behaves like 0x8001 and 0xBFFE like 0xA000.
- R3: A write to 0x8000 takes the character-invert mode from data bit 7, the program-swap mode from bit 6 and the bank index from bits 2:0. The write alone changes no output.
- R4: A write to 0x8001 loads the indexed bank register with a reduced value. Indices 0 and 1 store (data with bit 0 cleared) mod CHR_PAGES. Indices 2..5 store data mod CHR_PAGES. Indices 6 and 7 store data mod PRG_PAGES.
- R5: With program-swap 0, program slots 0..3 (windows 0x8000, 0xA000, 0xC000, 0xE000) read reg6, reg7, PRG_PAGES-2, PRG_PAGES-1. With program-swap 1 they read PRG_PAGES-2, reg7, reg6, PRG_PAGES-1. Slot 3 is always the last page.
- R6: With character-invert 0, character slots 0..7 read reg0, reg0+1, reg1, reg1+1, reg2, reg3, reg4, reg5. With character-invert 1, slots 0..3 read reg2..reg5 and slots 4..7 read the paired group.
- R7: A write to 0xA000 sets mirror_out to the inverse of data bit 0 one clock later. A write to 0xA001 leaves mirror_out unchanged.
- R8: Writes whose masked address is not 0x8000, 0x8001, 0xA000 or 0xA001 change no bank register, mode, index or output.
- R9: A data-port write stores its bank value on its own clock edge. The page outputs reload on the following edge from the bank registers and modes held at that moment. The page outputs never change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 16 | Bus write address |
| wr_data | input | 8 | Bus write data |
| prg_page | output | 4*PRG_W | Program page numbers, slot s at bits [s*PRG_W +: PRG_W] |
| chr_page | output | 8*CHR_W | Character page numbers, slot s at bits [s*CHR_W +: CHR_W] |
| mirror_out | output | 1 | Mirroring control |

## Verification
Two functions can fall on the same clock edge: the output reload caused by a data-port write, and a select write that changes the modes for the next reload. The bench drives a select write in the cycle right after a data write. The reload must then use the old layout, and the new modes must stay unseen until the next data write. Back-to-back data writes are also driven, so that one reload overlaps with the next bank store. A behavioural reference model, written with plain integers, is compared against every output on every clock. Hand-computed values are also checked at the boundary points: modulo wrap, forced-even pairs, and aliased addresses.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

   localparam logic [15:0] BPM_DECODE_MASK = 16'hE001;
   localparam logic [15:0] BPM_SELECT_ADDR = 16'h8000;
   localparam logic [15:0] BPM_DATA_ADDR   = 16'h8001;
   localparam logic [15:0] BPM_MIRROR_ADDR = 16'hA000;
   localparam logic [15:0] BPM_SPARE_ADDR  = 16'hA001;

   localparam int BPM_NUM_BANKS = 8;
   localparam int BPM_PRG_SLOTS = 4;
   localparam int BPM_CHR_SLOTS = 8;

   typedef enum logic [2:0] {
      BPM_ACC_NONE,
      BPM_ACC_SELECT,
      BPM_ACC_DATA,
      BPM_ACC_MIRROR,
      BPM_ACC_SPARE
   } bpm_access_e;

   // power-up contents of bank register idx
   function automatic logic [7:0] bpm_reset_bank(input int idx);
      if (idx < 2)      return 8'(2 * idx);
      else if (idx < 6) return 8'(idx + 2);
      else              return 8'(idx - 6);
   endfunction

endpackage

// File: rtl/bpm_decode.sv
module bpm_decode
   import bpm_pkg::*;
(
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   output bpm_access_e access
);

   logic [15:0] masked;

   assign masked = wr_addr & BPM_DECODE_MASK;

   always_comb begin
      access = BPM_ACC_NONE;
      if (wr_en) begin
         case (masked)
            BPM_SELECT_ADDR: access = BPM_ACC_SELECT;
            BPM_DATA_ADDR:   access = BPM_ACC_DATA;
            BPM_MIRROR_ADDR: access = BPM_ACC_MIRROR;
            BPM_SPARE_ADDR:  access = BPM_ACC_SPARE;
            default:         access = BPM_ACC_NONE;
         endcase
      end
   end

endmodule

// File: rtl/bpm_bank_file.sv
module bpm_bank_file
   import bpm_pkg::*;
#(
   parameter int PRG_PAGES = 12,
   parameter int CHR_PAGES = 96
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  bpm_access_e                        access,
   input  logic [7:0]                         wr_data,
   output logic                               chr_invert,
   output logic                               prg_swap,
   output logic [BPM_NUM_BANKS-1:0][7:0]      bank,
   output logic                               commit
);

   localparam int IDX_W = $clog2(BPM_NUM_BANKS);

   logic [IDX_W-1:0] sel_q;
   logic [7:0]       reduced;

   // range reduction chosen by the target index
   always_comb begin
      if (sel_q < IDX_W'(2))
         reduced = 8'((wr_data & 8'hFE) % CHR_PAGES);
      else if (sel_q < IDX_W'(6))
         reduced = 8'(wr_data % CHR_PAGES);
      else
         reduced = 8'(wr_data % PRG_PAGES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q      <= '0;
         chr_invert <= 1'b0;
         prg_swap   <= 1'b0;
      end else if (access == BPM_ACC_SELECT) begin
         sel_q      <= wr_data[IDX_W-1:0];
         chr_invert <= wr_data[7];
         prg_swap   <= wr_data[6];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BPM_NUM_BANKS; i++)
            bank[i] <= bpm_reset_bank(i);
      end else if (access == BPM_ACC_DATA) begin
         bank[sel_q] <= reduced;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) commit <= 1'b0;
      else        commit <= (access == BPM_ACC_DATA);
   end

   // R4
   pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_DATA && sel_q == IDX_W'(0)) |=> (bank[0][0] == 1'b0));

   // R4
   prg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_DATA) |=> (bank[6] < 8'(PRG_PAGES) && bank[7] < 8'(PRG_PAGES)));

   // R3
   select_keeps_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_SELECT) |=> $stable(bank));

   // R8
   foreign_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_NONE) |=> ($stable(chr_invert) && $stable(prg_swap) && $stable(bank)));

   // R9
   commit_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_DATA) |=> commit);

endmodule

// File: rtl/bpm_window_map.sv
module bpm_window_map
   import bpm_pkg::*;
#(
   parameter int PRG_PAGES = 12,
   parameter int CHR_PAGES = 96,
   parameter int PRG_W     = $clog2(PRG_PAGES),
   parameter int CHR_W     = $clog2(CHR_PAGES)
)(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                commit,
   input  logic                                chr_invert,
   input  logic                                prg_swap,
   input  logic [BPM_NUM_BANKS-1:0][7:0]       bank,
   output logic [BPM_PRG_SLOTS*PRG_W-1:0]      prg_page,
   output logic [BPM_CHR_SLOTS*CHR_W-1:0]      chr_page
);

   localparam int HALF = BPM_CHR_SLOTS / 2;

   logic [7:0] prg_nx   [BPM_PRG_SLOTS];
   logic [7:0] chr_nx   [BPM_CHR_SLOTS];
   logic [7:0] paired   [HALF];
   logic [7:0] single   [HALF];

   always_comb begin
      prg_nx[0] = prg_swap ? 8'(PRG_PAGES - 2) : bank[6];
      prg_nx[1] = bank[7];
      prg_nx[2] = prg_swap ? bank[6] : 8'(PRG_PAGES - 2);
      prg_nx[3] = 8'(PRG_PAGES - 1);
   end

   // 2 KB registers cover two adjacent 1 KB slots; their stored value is even
   always_comb begin
      paired[0] = bank[0];
      paired[1] = bank[0] | 8'h01;
      paired[2] = bank[1];
      paired[3] = bank[1] | 8'h01;
      for (int k = 0; k < HALF; k++)
         single[k] = bank[2 + k];
   end

   always_comb begin
      for (int s = 0; s < HALF; s++) begin
         chr_nx[s]        = chr_invert ? single[s] : paired[s];
         chr_nx[s + HALF] = chr_invert ? paired[s] : single[s];
      end
   end

   for (genvar g = 0; g < BPM_PRG_SLOTS; g++) begin : g_prg
      localparam int RST = (g < 2) ? g : (PRG_PAGES - BPM_PRG_SLOTS + g);
      logic [PRG_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q <= PRG_W'(RST);
         else if (commit) slot_q <= PRG_W'(prg_nx[g]);
      end
      assign prg_page[g*PRG_W +: PRG_W] = slot_q;
   end

   for (genvar g = 0; g < BPM_CHR_SLOTS; g++) begin : g_chr
      logic [CHR_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q <= CHR_W'(g);
         else if (commit) slot_q <= CHR_W'(chr_nx[g]);
      end
      assign chr_page[g*CHR_W +: CHR_W] = slot_q;
   end

   // R9
   hold_without_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(prg_page) && $stable(chr_page)));

   // R5
   last_page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_page[3*PRG_W +: PRG_W] == PRG_W'(PRG_PAGES - 1));

   // R6
   pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !chr_invert) |=>
         (chr_page[1*CHR_W +: CHR_W] == CHR_W'(chr_page[0 +: CHR_W] + 1'b1)));

endmodule

// File: rtl/bank_page_mapper.sv
module bank_page_mapper
   import bpm_pkg::*;
#(
   parameter int PRG_PAGES = 12,
   parameter int CHR_PAGES = 96,
   localparam int PRG_W    = $clog2(PRG_PAGES),
   localparam int CHR_W    = $clog2(CHR_PAGES)
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [15:0]                       wr_addr,
   input  logic [7:0]                        wr_data,
   output logic [BPM_PRG_SLOTS*PRG_W-1:0]    prg_page,
   output logic [BPM_CHR_SLOTS*CHR_W-1:0]    chr_page,
   output logic                              mirror_out
);

   if (PRG_PAGES < 4 || PRG_PAGES > 256) begin : g_bad_prg
      $error("PRG_PAGES must lie in 4..256");
   end
   if (CHR_PAGES < 8 || CHR_PAGES > 256 || (CHR_PAGES % 2) != 0) begin : g_bad_chr
      $error("CHR_PAGES must be even and lie in 8..256");
   end

   bpm_access_e                   access;
   logic                          chr_invert;
   logic                          prg_swap;
   logic                          commit;
   logic [BPM_NUM_BANKS-1:0][7:0] bank;

   bpm_decode u_decode (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .access  (access)
   );

   bpm_bank_file #(
      .PRG_PAGES (PRG_PAGES),
      .CHR_PAGES (CHR_PAGES)
   ) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .access     (access),
      .wr_data    (wr_data),
      .chr_invert (chr_invert),
      .prg_swap   (prg_swap),
      .bank       (bank),
      .commit     (commit)
   );

   bpm_window_map #(
      .PRG_PAGES (PRG_PAGES),
      .CHR_PAGES (CHR_PAGES),
      .PRG_W     (PRG_W),
      .CHR_W     (CHR_W)
   ) u_windows (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (commit),
      .chr_invert (chr_invert),
      .prg_swap   (prg_swap),
      .bank       (bank),
      .prg_page   (prg_page),
      .chr_page   (chr_page)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mirror_out <= 1'b0;
      else if (access == BPM_ACC_MIRROR) mirror_out <= ~wr_data[0];
   end

   // R7
   mirror_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_MIRROR) |=> (mirror_out == !$past(wr_data[0])));

   // R7
   spare_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access == BPM_ACC_SPARE) |=> $stable(mirror_out));

   // R2
   alias_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[15:13] == 3'b100 && wr_addr[0]) |=> commit);

endmodule

// File: tb/bank_page_mapper_tb.sv
module bank_page_mapper_tb;

   localparam int PRG_PAGES = 12;
   localparam int CHR_PAGES = 96;
   localparam int PW = 4;
   localparam int CW = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [15:0]     wr_addr = '0;
   logic [7:0]      wr_data = '0;
   logic [4*PW-1:0] prg_page;
   logic [8*CW-1:0] chr_page;
   logic            mirror_out;

   always #4 clk = ~clk;

   bank_page_mapper #(.PRG_PAGES(PRG_PAGES), .CHR_PAGES(CHR_PAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prg_page(prg_page), .chr_page(chr_page),
      .mirror_out(mirror_out)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   string phase   = "R1";

   // behavioural reference
   int m_bank [8];
   bit m_inv, m_swap, m_commit;
   int m_sel;
   int e_prg [4];
   int e_chr [8];
   bit e_mir;

   task automatic model_reset();
      m_bank = '{0, 2, 4, 5, 6, 7, 0, 1};
      m_inv = 0; m_swap = 0; m_commit = 0; m_sel = 0;
      e_prg = '{0, 1, PRG_PAGES - 2, PRG_PAGES - 1};
      for (int i = 0; i < 8; i++) e_chr[i] = i;
      e_mir = 0;
   endtask

   task automatic model_remap();
      int pair_v [4];
      int one_v [4];
      e_prg[0] = m_swap ? PRG_PAGES - 2 : m_bank[6];
      e_prg[1] = m_bank[7];
      e_prg[2] = m_swap ? m_bank[6] : PRG_PAGES - 2;
      e_prg[3] = PRG_PAGES - 1;
      pair_v = '{m_bank[0], m_bank[0] + 1, m_bank[1], m_bank[1] + 1};
      one_v  = '{m_bank[2], m_bank[3], m_bank[4], m_bank[5]};
      for (int i = 0; i < 4; i++) begin
         e_chr[i]     = m_inv ? one_v[i]  : pair_v[i];
         e_chr[i + 4] = m_inv ? pair_v[i] : one_v[i];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int a;
         int d;
         if (m_commit) model_remap();
         m_commit = 0;
         if (wr_en) begin
            a = int'(wr_addr) & 'hE001;
            d = int'(wr_data);
            if (a == 'h8000) begin
               m_inv = d[7]; m_swap = d[6]; m_sel = d & 7;
            end else if (a == 'h8001) begin
               if (m_sel < 2)      m_bank[m_sel] = (d & 'hFE) % CHR_PAGES;
               else if (m_sel < 6) m_bank[m_sel] = d % CHR_PAGES;
               else                m_bank[m_sel] = d % PRG_PAGES;
               m_commit = 1;
            end else if (a == 'hA000) begin
               e_mir = ~d[0];
            end
         end
      end
   end

   task automatic check(string tag, string what, int got, int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   function automatic int prg_at(int s);
      return int'(prg_page[s*PW +: PW]);
   endfunction

   function automatic int chr_at(int s);
      return int'(chr_page[s*CW +: CW]);
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         for (int s = 0; s < 4; s++) check(phase, $sformatf("prg slot %0d", s), prg_at(s), e_prg[s]);
         for (int s = 0; s < 8; s++) check(phase, $sformatf("chr slot %0d", s), chr_at(s), e_chr[s]);
         check(phase, "mirror", int'(mirror_out), int'(e_mir));
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R1 reset layout
      phase = "R1";
      check("R1", "prg0", prg_at(0), 0);
      check("R1", "prg2", prg_at(2), 10);
      check("R1", "prg3", prg_at(3), 11);
      check("R1", "chr7", chr_at(7), 7);
      check("R1", "mirror", int'(mirror_out), 0);

      // R3 select write alone moves nothing
      phase = "R3";
      wr(16'h8000, 8'hC6);
      idle(3);
      check("R3", "prg0 after select only", prg_at(0), 0);
      check("R3", "chr0 after select only", chr_at(0), 0);

      // R5 / R6 swapped layouts after a data write, with wrap 13 mod 12
      phase = "R5";
      wr(16'h8001, 8'd13);
      idle(3);
      check("R5", "prg0 swapped", prg_at(0), 10);
      check("R5", "prg2 swapped", prg_at(2), 1);
      check("R6", "chr0 inverted", chr_at(0), 4);
      check("R6", "chr5 inverted", chr_at(5), 1);

      phase = "R5";
      wr(16'h8000, 8'h07);
      wr(16'h8001, 8'h0B);
      idle(3);
      check("R5", "prg0 normal", prg_at(0), 1);
      check("R5", "prg1 normal", prg_at(1), 11);
      check("R5", "prg2 normal", prg_at(2), 10);

      // R4 reductions: 99 -> even 98 mod 96 = 2 ; 255 mod 96 = 63
      phase = "R4";
      wr(16'h8000, 8'h00);
      wr(16'h8001, 8'd99);
      wr(16'h8000, 8'h02);
      wr(16'h8001, 8'hFF);
      idle(3);
      check("R4", "chr0 pair", chr_at(0), 2);
      check("R4", "chr1 pair", chr_at(1), 3);
      check("R4", "chr4 wrap", chr_at(4), 63);

      // R2 aliasing through the mask
      phase = "R2";
      wr(16'h9FFE, 8'h03);
      wr(16'h9FFF, 8'd80);
      wr(16'hBFFE, 8'h00);
      idle(3);
      check("R2", "chr5 via alias", chr_at(5), 80);
      check("R2", "mirror via alias", int'(mirror_out), 1);

      // R7 mirror set and spare ignored
      phase = "R7";
      wr(16'hA000, 8'h01);
      idle(2);
      check("R7", "mirror cleared", int'(mirror_out), 0);
      wr(16'hA001, 8'h00);
      idle(2);
      check("R7", "spare ignored", int'(mirror_out), 0);

      // R8 writes elsewhere leave state alone
      phase = "R8";
      wr(16'h6000, 8'hC5);
      wr(16'hC000, 8'h86);
      wr(16'hE001, 8'h47);
      wr(16'h0001, 8'h33);
      wr(16'hC001, 8'h11);
      idle(3);
      check("R8", "chr5 unchanged", chr_at(5), 80);
      wr(16'h8001, 8'd8);
      idle(3);
      check("R8", "index kept at 3", chr_at(5), 8);
      check("R8", "chr4 kept", chr_at(4), 63);
      check("R8", "prg0 kept", prg_at(0), 1);

      // R9 reload and mode change in the same edge; back-to-back data writes
      phase = "R9";
      wr(16'h8000, 8'h06);
      wr(16'h8001, 8'd4);
      wr(16'h8000, 8'hC0);
      idle(5);
      check("R9", "prg0 old layout", prg_at(0), 4);
      check("R9", "chr0 old layout", chr_at(0), 2);
      wr(16'h8001, 8'd6);
      wr(16'h8001, 8'd12);
      idle(4);
      check("R9", "prg0 new layout", prg_at(0), 10);
      check("R9", "prg2 new layout", prg_at(2), 4);
      check("R9", "chr4 second write", chr_at(4), 12);
      check("R9", "chr5 pair", chr_at(5), 13);

      idle(2);
      finish_run();
   end

endmodule